// File: doc/BRIEF.md
# DRAM Refresh Sequencer

This block keeps one DRAM rank refreshed. A free-running interval counter raises a refresh request every `T_REFI` cycles. On a request the block raises its access-block output, so the surrounding controller stops sending reads and writes. If any bank is open, it waits until every open bank may legally be closed. It then closes all banks at once with a precharge-all command, waits `T_RP` cycles and issues the refresh command. After `T_RFC` more cycles it releases the block. When no bank is open at the time of the request, the precharge-all step is skipped and the refresh command follows at once.

Alongside the refresh sequence, the block reports the power state of the rank: idle when all banks are closed, active when at least one is open, and refresh for the whole time the access block is held. A counter accumulates the cycles spent in the idle state. Refresh time is never added to that count, even though all banks are closed during a refresh.

The interval counter reloads at the moment a request is raised, not when the refresh finishes. The start of each refresh therefore keeps a fixed pitch and does not drift with the length of each sequence.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset, `block_o` rises for the first time on the `T_REFI`-th clock edge. Later rising edges of `block_o` follow one another exactly `T_REFI` cycles apart, whatever the sequence length.
- R2: `block_o` stays high from the start of a refresh until the end of the `T_RFC` wait. A non-zero command on `cmd_o` appears only while `block_o` is high.
- R3: Precharge-all (`cmd_o` = 2'b01) is issued only when at least one bank is open and every open bank has its `pre_ok_i` bit set. The `pre_ok_i` bits of closed banks have no effect.
- R4: Refresh (`cmd_o` = 2'b10) follows a precharge-all exactly `T_RP` cycles later. Each command is a one-cycle pulse, and `cmd_o` is 2'b00 in the cycles between.
- R5: If no bank is open when the sequence starts, no precharge-all is issued, and the refresh command appears in the cycle after `block_o` rises.
- R6: `block_o` falls exactly `T_RFC` cycles after the refresh command.
- R7: `pwr_o` is 2'b10 (refresh) exactly while `block_o` is high. Otherwise it is 2'b01 (active) if any bank was open in the previous cycle, and 2'b00 (idle) if none was.
- R8: `idle_cnt_o` increases by one for each cycle in which `pwr_o` is idle, and holds its value while `pwr_o` is refresh.
- R9: While `rst` is high, `cmd_o` is 2'b00, `block_o` is 0, `pwr_o` is idle and `idle_cnt_o` is 0, and the interval counter restarts from its full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_open_i | input | NUM_BANKS | One bit per bank, set while that bank holds an open row |
| pre_ok_i | input | NUM_BANKS | One bit per bank, set once that bank has reached its earliest allowed precharge time |
| cmd_o | output | 2 | Command pulse: 00 none, 01 precharge-all, 10 refresh |
| block_o | output | 1 | High while reads and writes must not be issued |
| pwr_o | output | 2 | Rank power state: 00 idle, 01 active, 10 refresh |
| idle_cnt_o | output | IDLE_W | Number of cycles spent in the idle state (wraps) |

## Verification
The assertion that a refresh command sees no open bank in the preceding cycle depends on the external bank tracker. That tracker must clear every open flag within `T_RP` cycles of a precharge-all, and must open no bank while `block_o` is high. The stimulus clears `bank_open_i` in the cycle the precharge-all appears, and changes it only between sequences. It also keeps the longest precharge-permission delay well inside one refresh interval, so a request never arrives while a sequence is still running.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_PREA = 2'b01,
    CMD_REF  = 2'b10
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_IDLE    = 2'b00,
    PWR_ACTIVE  = 2'b01,
    PWR_REFRESH = 2'b10
  } pwr_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_PREP,
    ST_TRP,
    ST_TRFC
  } seq_e;
endpackage

// File: rtl/dram_refi_timer.sv
module dram_refi_timer #(
  parameter int T_REFI = 3900
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = $clog2(T_REFI + 1);

  logic [CW-1:0] cnt_q;

  // Reload happens on the request itself, so the pitch never drifts.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CW'(T_REFI - 1);
    end else if (cnt_q == '0) begin
      cnt_q <= CW'(T_REFI - 1);
    end else begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/dram_ref_fsm.sv
module dram_ref_fsm
  import dram_ref_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int T_RP      = 15,
  parameter int T_RFC     = 280
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  input  logic [NUM_BANKS-1:0] pre_ok_i,
  output cmd_e                 cmd_o,
  output logic                 block_o,
  output logic                 block_nxt_o
);
  localparam int WMAX   = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int WAIT_W = $clog2(WMAX + 1);

  seq_e              st_q, st_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  cmd_e              cmd_d;
  logic              owe_q, owe_d;
  logic              any_open;
  logic              close_ok;

  assign any_open = |bank_open_i;
  assign close_ok = &(pre_ok_i | ~bank_open_i);

  always_comb begin
    st_d   = st_q;
    wait_d = wait_q;
    cmd_d  = CMD_NONE;
    owe_d  = owe_q | (tick_i && (st_q != ST_RUN));
    case (st_q)
      ST_RUN: begin
        if (tick_i || owe_q) begin
          st_d  = ST_PREP;
          owe_d = 1'b0;
        end
      end
      ST_PREP: begin
        if (!any_open) begin
          cmd_d  = CMD_REF;
          wait_d = WAIT_W'(T_RFC - 1);
          st_d   = ST_TRFC;
        end else if (close_ok) begin
          cmd_d  = CMD_PREA;
          wait_d = WAIT_W'(T_RP - 1);
          st_d   = ST_TRP;
        end
      end
      ST_TRP: begin
        if (wait_q == '0) begin
          cmd_d  = CMD_REF;
          wait_d = WAIT_W'(T_RFC - 1);
          st_d   = ST_TRFC;
        end else begin
          wait_d = wait_q - WAIT_W'(1);
        end
      end
      default: begin
        if (wait_q == '0) begin
          st_d = ST_RUN;
        end else begin
          wait_d = wait_q - WAIT_W'(1);
        end
      end
    endcase
  end

  assign block_nxt_o = (st_d != ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_RUN;
      wait_q  <= '0;
      cmd_o   <= CMD_NONE;
      owe_q   <= 1'b0;
      block_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      wait_q  <= wait_d;
      cmd_o   <= cmd_d;
      owe_q   <= owe_d;
      block_o <= block_nxt_o;
    end
  end
endmodule

// File: rtl/dram_pwr_track.sv
module dram_pwr_track
  import dram_ref_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int IDLE_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 refresh_nxt_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  output pwr_e                 pwr_o,
  output logic [IDLE_W-1:0]    idle_cnt_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_o      <= PWR_IDLE;
      idle_cnt_o <= '0;
    end else begin
      if (refresh_nxt_i) begin
        pwr_o <= PWR_REFRESH;
      end else if (|bank_open_i) begin
        pwr_o <= PWR_ACTIVE;
      end else begin
        pwr_o <= PWR_IDLE;
      end
      if (pwr_o == PWR_IDLE) begin
        idle_cnt_o <= idle_cnt_o + IDLE_W'(1);
      end
    end
  end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int T_REFI    = 3900,
  parameter int T_RP      = 15,
  parameter int T_RFC     = 280,
  parameter int IDLE_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  input  logic [NUM_BANKS-1:0] pre_ok_i,
  output logic [1:0]           cmd_o,
  output logic                 block_o,
  output logic [1:0]           pwr_o,
  output logic [IDLE_W-1:0]    idle_cnt_o
);
  logic tick;
  logic block_nxt;
  cmd_e cmd_q;
  pwr_e pwr_q;

  dram_refi_timer #(.T_REFI(T_REFI)) i_timer (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  dram_ref_fsm #(
    .NUM_BANKS (NUM_BANKS),
    .T_RP      (T_RP),
    .T_RFC     (T_RFC)
  ) i_fsm (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick),
    .bank_open_i (bank_open_i),
    .pre_ok_i    (pre_ok_i),
    .cmd_o       (cmd_q),
    .block_o     (block_o),
    .block_nxt_o (block_nxt)
  );

  dram_pwr_track #(
    .NUM_BANKS (NUM_BANKS),
    .IDLE_W    (IDLE_W)
  ) i_pwr (
    .clk           (clk),
    .rst           (rst),
    .refresh_nxt_i (block_nxt),
    .bank_open_i   (bank_open_i),
    .pwr_o         (pwr_q),
    .idle_cnt_o    (idle_cnt_o)
  );

  assign cmd_o = cmd_q;
  assign pwr_o = pwr_q;
endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
  parameter int NUM_BANKS = 8,
  parameter int IDLE_W    = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_BANKS-1:0] bank_open_i,
  input logic [NUM_BANKS-1:0] pre_ok_i,
  input logic [1:0]           cmd_o,
  input logic                 block_o,
  input logic [1:0]           pwr_o,
  input logic [IDLE_W-1:0]    idle_cnt_o
);
  // R2
  cmd_only_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o != 2'b00) |-> block_o);

  // R3
  prea_permitted_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 2'b01) |-> ($past(|bank_open_i) && $past(&(pre_ok_i | ~bank_open_i))));

  // R4
  ref_banks_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 2'b10) |-> ($past(bank_open_i) == '0));

  // R7
  pwr_tracks_block_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_o == 2'b10) == block_o);

  // R8
  idle_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_o == 2'b10) |=> $stable(idle_cnt_o));
endmodule

bind dram_refresh_seq dram_refresh_chk #(
  .NUM_BANKS (NUM_BANKS),
  .IDLE_W    (IDLE_W)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .bank_open_i (bank_open_i),
  .pre_ok_i    (pre_ok_i),
  .cmd_o       (cmd_o),
  .block_o     (block_o),
  .pwr_o       (pwr_o),
  .idle_cnt_o  (idle_cnt_o)
);

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;
  localparam int NB     = 4;
  localparam int T_REFI = 40;
  localparam int T_RP   = 3;
  localparam int T_RFC  = 6;
  localparam int IDLE_W = 16;
  // each row: {open bank mask, cycles before precharge permission}
  localparam logic [7:0] VEC [6] = '{8'h00, 8'h10, 8'hF5, 8'h53, 8'h00, 8'h89};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NB-1:0]     bank_open_i = '0;
  logic [NB-1:0]     pre_ok_i = '0;
  logic [1:0]        cmd_o;
  logic              block_o;
  logic [1:0]        pwr_o;
  logic [IDLE_W-1:0] idle_cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  dram_refresh_seq #(
    .NUM_BANKS (NB),
    .T_REFI    (T_REFI),
    .T_RP      (T_RP),
    .T_RFC     (T_RFC),
    .IDLE_W    (IDLE_W)
  ) i_dram_refresh_seq (
    .clk         (clk),
    .rst         (rst),
    .bank_open_i (bank_open_i),
    .pre_ok_i    (pre_ok_i),
    .cmd_o       (cmd_o),
    .block_o     (block_o),
    .pwr_o       (pwr_o),
    .idle_cnt_o  (idle_cnt_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_block(output int t);
    int guard = 0;
    while (!block_o && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    t = cyc;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int prev_t = -1;
    int t;
    int base;
    logic [IDLE_W-1:0] idle0;

    repeat (3) @(negedge clk);
    // R9 reset values
    check(cmd_o == 2'b00, "R9 cmd", int'(cmd_o), 0);
    check(block_o == 1'b0, "R9 block", int'(block_o), 0);
    check(pwr_o == 2'b00, "R9 pwr", int'(pwr_o), 0);
    check(idle_cnt_o == '0, "R9 idle", int'(idle_cnt_o), 0);
    rst = 1'b0;
    base = cyc;
    // R8 idle count grows by one per idle cycle
    @(negedge clk);
    idle0 = idle_cnt_o;
    repeat (5) @(negedge clk);
    check(idle_cnt_o == idle0 + 5, "R8 idle growth", int'(idle_cnt_o), int'(idle0) + 5);
    // R1 first request on edge T_REFI after reset
    wait_block(t);
    check(t - base == T_REFI, "R1 first request", t - base, T_REFI);
    // finish this first sequence (no bank open)
    @(negedge clk);
    check(cmd_o == 2'b10, "R5 first ref", int'(cmd_o), 2);
    repeat (T_RFC) @(negedge clk);
    prev_t = t;

    for (int i = 0; i < 6; i++) begin
      logic [NB-1:0] mask;
      int dly;
      mask = VEC[i][7:4];
      dly  = int'(VEC[i][3:0]);
      @(negedge clk);
      bank_open_i = mask;
      pre_ok_i    = ~mask;
      if (mask != '0) begin
        @(negedge clk);
        check(pwr_o == 2'b01, "R7 active", int'(pwr_o), 1);
      end
      wait_block(t);
      check(t - prev_t == T_REFI, "R1 pitch", t - prev_t, T_REFI);
      check(pwr_o == 2'b10, "R7 refresh", int'(pwr_o), 2);
      prev_t = t;
      if (mask != '0) begin
        for (int k = 0; k < dly; k++) begin
          @(negedge clk);
          check(cmd_o == 2'b00, "R3 held back", int'(cmd_o), 0);
        end
        pre_ok_i = '1;
        @(negedge clk);
        check(cmd_o == 2'b01, "R3 prea", int'(cmd_o), 1);
        bank_open_i = '0;
        for (int k = 1; k <= T_RP; k++) begin
          @(negedge clk);
          if (k < T_RP) check(cmd_o == 2'b00, "R4 gap", int'(cmd_o), 0);
          else          check(cmd_o == 2'b10, "R4 ref after trp", int'(cmd_o), 2);
        end
      end else begin
        @(negedge clk);
        check(cmd_o == 2'b10, "R5 direct ref", int'(cmd_o), 2);
      end
      idle0 = idle_cnt_o;
      for (int k = 1; k <= T_RFC; k++) begin
        @(negedge clk);
        if (k < T_RFC) begin
          check(block_o == 1'b1, "R2 block held", int'(block_o), 1);
        end else begin
          check(block_o == 1'b0, "R6 release", int'(block_o), 0);
          check(pwr_o == 2'b00, "R7 idle after", int'(pwr_o), 0);
          check(idle_cnt_o == idle0, "R8 frozen", int'(idle_cnt_o), int'(idle0));
        end
      end
    end

    // R9 reset in the middle of a sequence
    bank_open_i = '0;
    wait_block(t);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(block_o == 1'b0, "R9 mid block", int'(block_o), 0);
    check(cmd_o == 2'b00, "R9 mid cmd", int'(cmd_o), 0);
    check(pwr_o == 2'b00, "R9 mid pwr", int'(pwr_o), 0);
    check(idle_cnt_o == '0, "R9 mid idle", int'(idle_cnt_o), 0);
    rst = 1'b0;
    base = cyc;
    wait_block(t);
    check(t - base == T_REFI, "R9 timer restart", t - base, T_REFI);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule